// File: doc/BRIEF.md
# Pipelined Parallel CRC Divider

This block divides a message by a fixed generator polynomial and returns the remainder. The message arrives as P-bit words, one word per clock. Each word is sent most significant bit first. The remainder starts from zero, the input is not reflected, and no final XOR is applied.

The work is not done by one wide XOR tree per word. The P single-bit multiply-by-X-and-reduce steps are spread over a chain of registered stages. Each stage consumes one data bit. The bits a word has not yet used travel beside it in a shrinking skew register, so each bit reaches its stage on its own cycle. The last step sits inside the accumulator. On every cycle that a word lands, the accumulator multiplies the running remainder by X^P modulo G and adds the word's own remainder. The X^P matrix is worked out at elaboration from the polynomial and the word width.

A message starts with a word flagged as start and ends with a word flagged as last. After the last word has landed, a done flag rises. The done flag and the remainder then stay still until the next start, so the block can serve as a frame checker.

Top module: `crc_pipe_div`

## Requirements
- R1: After a message has fully landed, the remainder equals the result of a bit-serial divider. That divider starts from zero, takes each word most significant bit first, and on every bit does: feedback = rem[W-1] xor bit, then rem = (rem << 1) xor (feedback ? POLY : 0), truncated to W bits.
- R2: With W=16, P=8 and POLY=16'h1021, the ASCII message "123456789" (one byte per word) gives the remainder 16'h31C3.
- R3: Call the rising edge that accepts the last word edge 1. The done flag is low after edges 1 to P-1 and first reads high after edge P. This holds for every width.
- R4: in_ready stays high once it has risen. Words are taken back to back, one per clock. A cycle with in_valid low changes nothing, whatever in_sop, in_last and in_data hold in that cycle.
- R5: A start word is accepted when in_valid, in_ready and in_sop are all high. It clears the remainder and the done flag on the edge that accepts it, and both read zero after that edge. Words of an earlier message still in the pipeline are discarded, even one that lands on that same edge.
- R6: After done rises, the done flag stays high and the remainder stays unchanged until a start word is accepted. Words offered after the last word without in_sop are ignored.
- R7: While rst_n is low, crc_rem is zero and crc_done and in_ready are low. in_ready reads high no later than the fourth rising edge after rst_n is released.
- R8: A message of all-zero words gives a zero remainder.
- R9: A single word flagged with both in_sop and in_last forms a complete message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A data word is present |
| in_ready | output | 1 | The block takes words (high after reset) |
| in_sop | input | 1 | The word is the first of a message |
| in_last | input | 1 | The word is the last of a message |
| in_data | input | P | Message word, most significant bit first |
| crc_rem | output | W | Running remainder |
| crc_done | output | 1 | The remainder of the whole message is ready |

## Verification
The start clear and the landing of an older word in the accumulator can happen on the same edge. To provoke this, a new start is issued straight after a 40-word message that has no last word. At that moment the pipeline is full of the old words in every configuration. The result is judged in two ways: the remainder and done flag must read zero one edge after the start, and the final remainder must match a serial model fed only with the new message.

// File: rtl/crc_pipe_pkg.sv
package crc_pipe_pkg;

  localparam int CRC_VEC_W = 64;

  typedef logic [CRC_VEC_W-1:0] crc_vec_t;

  // one serial division step on a zero-extended remainder of width w
  function automatic crc_vec_t crc_step(crc_vec_t r, logic b, crc_vec_t poly, int w);
    logic     fb;
    crc_vec_t n;
    crc_vec_t m;
    m = '0;
    for (int i = 0; i < CRC_VEC_W; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    fb = r[w-1] ^ b;
    n  = r << 1;
    if (fb) n = n ^ poly;
    return n & m;
  endfunction

  // column col of the matrix X^p mod G: image of the unit vector e_col
  function automatic crc_vec_t crc_xp_col(int col, int p, crc_vec_t poly, int w);
    crc_vec_t r;
    r      = '0;
    r[col] = 1'b1;
    for (int s = 0; s < p; s++) begin
      r = crc_step(r, 1'b0, poly, w);
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end

endmodule

// File: rtl/crc_stage.sv
// One registered multiply-by-X / reduce step. It consumes the top bit of the
// word it carries and forwards the remaining IW-1 bits.
module crc_stage #(
  parameter int             W    = 32,
  parameter int             IW   = 32,
  parameter logic [W-1:0]   POLY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_last,
  input  logic          flush,
  input  logic [W-1:0]  in_rem,
  input  logic [IW-1:0] in_word,
  output logic          out_vld,
  output logic          out_last,
  output logic [W-1:0]  out_rem,
  output logic [IW-2:0] out_word
);

  logic         vld_d;
  logic         fb;
  logic [W-1:0] rem_d;

  always_comb begin
    fb    = in_rem[W-1] ^ in_word[IW-1];
    rem_d = {in_rem[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    vld_d = in_vld & ~flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= vld_d;
  end

  // payload registers carry no reset, loaded only with a valid word
  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_last <= in_last;
      out_rem  <= rem_d;
      out_word <= in_word[IW-2:0];
    end
  end

endmodule

// File: rtl/crc_accum.sv
// Final division step plus running remainder: acc' = acc*X^P mod G + word remainder.
module crc_accum
  import crc_pipe_pkg::*;
#(
  parameter int           W    = 32,
  parameter int           P    = 32,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         lnd_vld,
  input  logic         lnd_last,
  input  logic [W-1:0] lnd_rem,
  input  logic         lnd_bit,
  output logic [W-1:0] acc_q,
  output logic         done_q
);

  localparam crc_vec_t POLY_V = crc_vec_t'(POLY);

  logic [W-1:0] col_term [W];
  logic [W-1:0] fold;
  logic [W-1:0] word_rem;
  logic [W-1:0] acc_d;
  logic         done_d;
  logic         acc_en;
  logic         fb;

  for (genvar i = 0; i < W; i++) begin : g_col
    localparam crc_vec_t COL = crc_xp_col(i, P, POLY_V, W);
    assign col_term[i] = acc_q[i] ? COL[W-1:0] : '0;
  end

  always_comb begin
    fold = '0;
    for (int i = 0; i < W; i++) fold = fold ^ col_term[i];
    fb       = lnd_rem[W-1] ^ lnd_bit;
    word_rem = {lnd_rem[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    acc_en   = clr | lnd_vld;
    acc_d    = acc_q;
    done_d   = done_q;
    if (clr) begin
      acc_d  = '0;
      done_d = 1'b0;
    end else if (lnd_vld) begin
      acc_d = fold ^ word_rem;
      if (lnd_last) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/crc_pipe_div.sv
module crc_pipe_div
  import crc_pipe_pkg::*;
#(
  parameter int           W    = 32,
  parameter int           P    = 32,
  parameter logic [W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_sop,
  input  logic         in_last,
  input  logic [P-1:0] in_data,
  output logic [W-1:0] crc_rem,
  output logic         crc_done
);

  localparam int NSTG = P - 1;
  localparam int SKW  = (P * (P - 1)) / 2;

  // start of the skew slice leaving stage k (width P-k)
  function automatic int skw_off(int k);
    return (k - 1) * P - ((k - 1) * k) / 2;
  endfunction

  logic                  srst_n;
  logic                  ready_q;
  logic                  open_q;
  logic                  open_d;
  logic                  take;
  logic                  sop_take;
  logic [NSTG:1]         stg_vld;
  logic [NSTG:1]         stg_last;
  logic [NSTG:1][W-1:0]  stg_rem;
  logic [SKW-1:0]        skw;

  crc_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    sop_take = in_valid & ready_q & in_sop;
    take     = in_valid & ready_q & (in_sop | open_q);
    open_d   = open_q;
    if (in_valid & ready_q) begin
      if (in_sop)                 open_d = ~in_last;
      else if (open_q && in_last) open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ready_q <= 1'b0;
      open_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      open_q  <= open_d;
    end
  end

  for (genvar k = 1; k <= NSTG; k++) begin : g_stg
    if (k == 1) begin : g_first
      crc_stage #(.W(W), .IW(P), .POLY(POLY)) u_stg (
        .clk      (clk),
        .rst_n    (srst_n),
        .in_vld   (take),
        .in_last  (in_last),
        .flush    (1'b0),
        .in_rem   ('0),
        .in_word  (in_data),
        .out_vld  (stg_vld[k]),
        .out_last (stg_last[k]),
        .out_rem  (stg_rem[k]),
        .out_word (skw[skw_off(k) +: P-k])
      );
    end else begin : g_mid
      crc_stage #(.W(W), .IW(P-k+1), .POLY(POLY)) u_stg (
        .clk      (clk),
        .rst_n    (srst_n),
        .in_vld   (stg_vld[k-1]),
        .in_last  (stg_last[k-1]),
        .flush    (sop_take),
        .in_rem   (stg_rem[k-1]),
        .in_word  (skw[skw_off(k-1) +: P-k+1]),
        .out_vld  (stg_vld[k]),
        .out_last (stg_last[k]),
        .out_rem  (stg_rem[k]),
        .out_word (skw[skw_off(k) +: P-k])
      );
    end
  end

  crc_accum #(.W(W), .P(P), .POLY(POLY)) u_accum (
    .clk      (clk),
    .rst_n    (srst_n),
    .clr      (sop_take),
    .lnd_vld  (stg_vld[NSTG]),
    .lnd_last (stg_last[NSTG]),
    .lnd_rem  (stg_rem[NSTG]),
    .lnd_bit  (skw[SKW-1]),
    .acc_q    (crc_rem),
    .done_q   (crc_done)
  );

  assign in_ready = ready_q;

endmodule

// File: rtl/crc_pipe_div_chk.sv
module crc_pipe_div_chk #(
  parameter int W = 32,
  parameter int P = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_sop,
  input logic         in_last,
  input logic [W-1:0] crc_rem,
  input logic         crc_done
);

  localparam int AW = $clog2(P + 2) + 1;

  logic          sop_acc;
  logic          last_acc;
  logic          pend;
  logic [AW-1:0] age;

  assign sop_acc  = in_valid && in_ready && in_sop;
  assign last_acc = in_valid && in_ready && in_last;

  // counts edges since the accepted last word (edge of acceptance = 1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      age  <= '0;
    end else if (sop_acc) begin
      pend <= in_last;
      age  <= AW'(1);
    end else if (last_acc && !pend) begin
      pend <= 1'b1;
      age  <= AW'(1);
    end else if (pend && age <= AW'(P)) begin
      age  <= age + AW'(1);
    end
  end

  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_done) |-> (pend && age == AW'(P)));

  p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  p_sop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sop) |=> (crc_rem == '0 && !crc_done));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_done && !(in_valid && in_ready && in_sop)) |=> (crc_done && $stable(crc_rem)));

endmodule

bind crc_pipe_div crc_pipe_div_chk #(.W(W), .P(P)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_sop   (in_sop),
  .in_last  (in_last),
  .crc_rem  (crc_rem),
  .crc_done (crc_done)
);

// File: tb/crc_pipe_div_bench.sv
module crc_pipe_div_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_last;
  logic [31:0] din;

  logic        rdy32, done32, rdy8, done8, rdy16, done16;
  logic [31:0] rem32;
  logic [15:0] rem8;
  logic [2:0]  rem16;

  int          n_chk = 0;
  int          n_err = 0;
  bit          ended = 1'b0;
  bit          rdy_drop = 1'b0;
  logic [63:0] r32, r8, r16;
  logic [31:0] rng;

  // fields: length, seed, bubble mask, data mode (0 random, 1 zeros, 2 ones)
  localparam int N_VEC = 6;
  localparam logic [39:0] VEC [N_VEC] = '{
    {8'd1,  16'h1D2F, 8'h00, 8'd0},
    {8'd2,  16'hBEEF, 8'h00, 8'd2},
    {8'd7,  16'h0F0F, 8'h55, 8'd0},
    {8'd12, 16'h3C3C, 8'h00, 8'd1},
    {8'd20, 16'h7A11, 8'h81, 8'd0},
    {8'd33, 16'h5EED, 8'h00, 8'd0}
  };

  always #5 clk = ~clk;

  crc_pipe_div #(.W(32), .P(32), .POLY(32'h04C1_1DB7)) u_crc_pipe_div (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy32),
    .in_sop(in_sop), .in_last(in_last), .in_data(din),
    .crc_rem(rem32), .crc_done(done32));

  crc_pipe_div #(.W(16), .P(8), .POLY(16'h1021)) u_crc_pipe_div_p8 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy8),
    .in_sop(in_sop), .in_last(in_last), .in_data(din[7:0]),
    .crc_rem(rem8), .crc_done(done8));

  crc_pipe_div #(.W(3), .P(16), .POLY(3'b011)) u_crc_pipe_div_p16 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy16),
    .in_sop(in_sop), .in_last(in_last), .in_data(din[15:0]),
    .crc_rem(rem16), .crc_done(done16));

  function automatic logic [63:0] ser_div(logic [63:0] r, logic [31:0] d, int p,
                                          logic [63:0] poly, int w);
    logic [63:0] m;
    logic        fb;
    m = (64'd1 << w) - 64'd1;
    for (int b = p - 1; b >= 0; b--) begin
      fb = r[w-1] ^ d[b];
      r  = {r[62:0], 1'b0};
      if (fb) r = r ^ poly;
      r = r & m;
    end
    return r;
  endfunction

  function automatic logic [31:0] next_rand(logic [31:0] s);
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_word(input bit sop, input bit last, input logic [31:0] data);
    in_valid = 1'b1; in_sop = sop; in_last = last; din = data;
    if (!(rdy32 && rdy8 && rdy16)) rdy_drop = 1'b1;
    if (sop) begin r32 = '0; r8 = '0; r16 = '0; end
    r32 = ser_div(r32, data, 32, 64'h04C1_1DB7, 32);
    r8  = ser_div(r8,  data, 8,  64'h1021, 16);
    r16 = ser_div(r16, data, 16, 64'h3, 3);
    step();
  endtask

  task automatic bubble();
    rng = next_rand(rng);
    in_valid = 1'b0; in_sop = 1'b1; in_last = 1'b1; din = rng;
    step();
  endtask

  task automatic run_msg(input int len, input int mode, input logic [7:0] gap, input bit finish);
    string       s;
    logic [31:0] data;
    int          k32, k8, k16;
    s = "123456789";
    for (int i = 0; i < len; i++) begin
      if (gap[i % 8] && i > 0) bubble();
      rng = next_rand(rng);
      case (mode)
        1:       data = '0;
        2:       data = '1;
        3:       data = {24'h0, s[i]};
        default: data = rng;
      endcase
      put_word(i == 0, finish && (i == len - 1), data);
      if (i == 0) begin
        // R5: start clears remainder and done on its own edge
        chk(rem32 == '0 && rem8 == '0 && rem16 == '0 && !done32 && !done8 && !done16,
            "R5 clear after start", {rem32, rem8, rem16}, 64'h0);
      end
    end
    in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0;
    if (finish) begin
      k32 = 0; k8 = 0; k16 = 0;
      for (int k = 1; k <= 40; k++) begin
        if (k > 1) step();
        if (done32 && k32 == 0) k32 = k;
        if (done8  && k8  == 0) k8  = k;
        if (done16 && k16 == 0) k16 = k;
      end
      chk(k32 == 32, "R3 latency P=32", 64'(k32), 64'd32);
      chk(k8  == 8,  "R3 latency P=8",  64'(k8),  64'd8);
      chk(k16 == 16, "R3 latency P=16", 64'(k16), 64'd16);
      chk(rem32 == r32[31:0], "R1 remainder P=32", 64'(rem32), r32);
      chk(rem8  == r8[15:0],  "R1 remainder P=8",  64'(rem8),  r8);
      chk(rem16 == r16[2:0],  "R1 remainder P=16", 64'(rem16), r16);
    end
  endtask

  initial begin
    logic [31:0] snap32;
    logic [15:0] snap8;
    logic [2:0]  snap16;
    int          len;
    rst_n = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0; din = '0;
    rng = 32'h1234_5678;
    repeat (2) @(negedge clk);
    chk(rem32 == '0 && !done32 && !rdy32, "R7 reset state", {rem32, done32, rdy32}, 64'h0);
    chk(!rdy8 && !rdy16, "R7 ready low in reset", {rdy8, rdy16}, 64'h0);
    rst_n = 1'b1;
    repeat (4) step();
    chk(rdy32 && rdy8 && rdy16, "R7 ready after release", {rdy32, rdy8, rdy16}, 64'h7);

    // R2: known remainder for a byte message
    run_msg(9, 3, 8'h00, 1'b1);
    chk(rem8 == 16'h31C3, "R2 known value P=8", 64'(rem8), 64'h31C3);

    for (int v = 0; v < N_VEC; v++) begin
      rng = {VEC[v][31:16], ~VEC[v][31:16]};
      run_msg(int'(VEC[v][39:32]), int'(VEC[v][7:0]), VEC[v][15:8], 1'b1);
      if (VEC[v][7:0] == 8'd1)
        chk(rem32 == '0 && rem8 == '0 && rem16 == '0, "R8 zero message",
            {rem32, rem8, rem16}, 64'h0);
      if (VEC[v][39:32] == 8'd1)
        chk(done32 && done8 && done16 && rem32 == r32[31:0], "R9 single word",
            64'(rem32), r32);
    end

    for (int m = 0; m < 4; m++) begin
      rng = next_rand(rng);
      len = 1 + int'(rng % 24);
      run_msg(len, 0, rng[15:8], 1'b1);
    end

    // R6: hold after done, non-start words ignored
    snap32 = rem32; snap8 = rem8; snap16 = rem16;
    for (int j = 0; j < 6; j++) begin
      rng = next_rand(rng);
      in_valid = rng[0]; in_sop = 1'b0; in_last = rng[1]; din = rng;
      step();
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk(done32 && done8 && done16, "R6 done held", {done32, done8, done16}, 64'h7);
    chk(rem32 == snap32 && rem8 == snap8 && rem16 == snap16, "R6 remainder held",
        {rem32, rem8, rem16}, {snap32, snap8, snap16});

    // R5: new start while the previous message fills the pipeline
    run_msg(40, 0, 8'h00, 1'b0);
    run_msg(5, 0, 8'h24, 1'b1);
    chk(rem32 == r32[31:0], "R5 old words discarded", 64'(rem32), r32);

    // R4: ready never dropped while words were driven
    chk(!rdy_drop, "R4 back-to-back ready", 64'(rdy_drop), 64'h0);

    ended = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule